// File: doc/BRIEF.md
# Receive Packet Address and Length Filter

This block sits between a byte-wide packet stream and the receive buffer that software reads. Bytes arrive with a valid strobe, a first-byte marker and a last-byte marker. The block counts each packet as it arrives and takes the byte at offset 1 as the destination address. When the last byte arrives, it decides whether to keep the packet. The decision uses a two-bit address-check mode and a two-bit length mode, compared against an own-address value and a packet-length limit.

The outcome is not known until the end of a packet, so every byte goes into a staging bank while the packet is still arriving. An accepted packet becomes the readable buffer in one cycle. At that moment the read position returns to zero, the byte count takes the packet size, and a one-cycle receive pulse is raised. A rejected packet leaves the readable buffer exactly as it was. An unsupported length mode raises a one-cycle flag, and so does a packet longer than the buffer depth.

Top module: `rx_pkt_filter`

## Requirements
- R1: With address mode 2'b00, every packet that passes the length check is accepted, whatever its destination byte, including a packet of a single byte.
- R2: With address mode 2'b01, 2'b10 or 2'b11, a packet whose byte at offset 1 equals `cfg_own_addr` passes the address check. Mode 2'b01 rejects every other destination, 8'h00 and 8'hFF included.
- R3: With address mode 2'b10, destination 8'h00 is also accepted, but 8'hFF is not, unless it equals the own address.
- R4: With address mode 2'b11, destinations 8'h00 and 8'hFF are both accepted, in addition to the own address.
- R5: With a non-zero address mode, a packet of one byte has no destination byte and is rejected.
- R6: With length mode 2'b01, a packet is accepted only if its byte count is at most `cfg_pkt_len`.
- R7: With length mode 2'b00, a packet is accepted only if its byte count equals `cfg_pkt_len`.
- R8: With length mode 2'b10 or 2'b11, every packet is rejected. `len_mode_err` is high for exactly the one cycle after the clock edge that takes the last byte.
- R9: A packet of more than DEPTH bytes is rejected. `overflow_err` is high for the one cycle after its last byte is taken.
- R10: On acceptance, `rx_irq` is high for the one cycle after the last byte is taken. From that cycle on, `rx_count` equals the packet size, `rx_level` equals `rx_count`, and `rd_data` shows the packet bytes in arrival order, starting at offset 0.
- R11: A rejected packet raises no `rx_irq` and leaves `rx_count`, `rx_level` and the readable bytes unchanged.
- R12: A cycle with `rd_en` high advances the read position by one while `rx_level` is non-zero. With `rx_level` at zero, `rd_data` reads 8'h00 and `rd_en` changes nothing.
- R13: A valid byte that arrives outside a packet without `in_first` is ignored. A byte with `in_first` in the middle of a packet abandons that packet and starts a new one at offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Stream byte present this cycle |
| in_first | input | 1 | Byte is the first of a packet |
| in_last | input | 1 | Byte is the last of a packet |
| in_data | input | 8 | Stream byte |
| cfg_amode | input | 2 | Address-check mode |
| cfg_own_addr | input | 8 | Own address |
| cfg_lmode | input | 2 | Length mode |
| cfg_pkt_len | input | LW | Packet-length limit or exact length |
| rd_en | input | 1 | Advance the read position |
| rd_data | output | 8 | Byte at the read position, 0 when empty |
| rx_count | output | CW | Size of the last accepted packet |
| rx_level | output | CW | Bytes not yet read |
| rx_irq | output | 1 | One-cycle receive pulse |
| len_mode_err | output | 1 | One-cycle pulse for an unsupported length mode |
| overflow_err | output | 1 | One-cycle pulse for a packet longer than DEPTH |

## Verification
The assertions assume two things about the inputs. The configuration inputs hold steady from the first byte of a packet to its last. `in_first` and `in_last` matter only while `in_valid` is high. The stimulus changes configuration only between packets, and it drives all inputs on falling clock edges. It sweeps every address mode against every length mode, with the destination set to the own address, 8'h00, 8'hFF and an unrelated value, and with sizes just below, at and just above the length setting. The bench then covers the single-byte, full-depth and over-depth cases and drains the buffer past empty.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef logic [7:0] byte_t;

    typedef enum logic [1:0] {
        AMODE_OPEN           = 2'b00,
        AMODE_SELF           = 2'b01,
        AMODE_SELF_ZERO      = 2'b10,
        AMODE_SELF_ZERO_ONES = 2'b11
    } amode_e;

    typedef enum logic [1:0] {
        LMODE_EXACT = 2'b00,
        LMODE_UPTO  = 2'b01,
        LMODE_RSVA  = 2'b10,
        LMODE_RSVB  = 2'b11
    } lmode_e;

    // End-of-packet summary produced by the collector.
    typedef struct packed {
        logic  done;
        logic  ovf;
        logic  have_dst;
        byte_t dst;
    } pkt_end_t;

    // Decision taken on the last byte.
    typedef struct packed {
        logic accept;
        logic len_err;
        logic ovf_err;
    } verdict_t;

    function automatic logic dest_match(amode_e m, byte_t own, byte_t dst, logic have);
        logic ok;
        unique case (m)
            AMODE_OPEN:           ok = 1'b1;
            AMODE_SELF:           ok = have && (dst == own);
            AMODE_SELF_ZERO:      ok = have && ((dst == own) || (dst == 8'h00));
            AMODE_SELF_ZERO_ONES: ok = have && ((dst == own) || (dst == 8'h00) || (dst == 8'hFF));
            default:              ok = 1'b0;
        endcase
        return ok;
    endfunction

    function automatic logic lmode_known(lmode_e m);
        return (m == LMODE_EXACT) || (m == LMODE_UPTO);
    endfunction

endpackage

// File: rtl/rxf_collect.sv
module rxf_collect
    import rxf_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 2)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          in_first,
    input  logic          in_last,
    input  byte_t         in_data,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output byte_t         wr_data,
    output pkt_end_t      end_ev,
    output logic [CW-1:0] end_size
);

    logic          in_pkt_q;
    logic [CW-1:0] cnt_q;
    logic          ovf_q;
    byte_t         dst_q;

    logic          start, cont, take, room, ovf_now;
    logic [CW-1:0] idx;

    always_comb begin
        start   = in_valid && in_first;
        cont    = in_valid && !in_first && in_pkt_q;
        take    = start || cont;
        idx     = start ? '0 : cnt_q;
        room    = idx < CW'(DEPTH);
        ovf_now = !room || (cont && ovf_q);

        wr_en   = take && room;
        wr_addr = idx[AW-1:0];
        wr_data = in_data;

        end_ev.done     = take && in_last;
        end_ev.ovf      = ovf_now;
        end_ev.have_dst = (idx != '0);
        end_ev.dst      = (idx == CW'(1)) ? in_data : dst_q;
        end_size        = idx + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_pkt_q <= 1'b0;
            cnt_q    <= '0;
            ovf_q    <= 1'b0;
            dst_q    <= '0;
        end else if (take) begin
            in_pkt_q <= !in_last;
            cnt_q    <= room ? idx + CW'(1) : idx;
            ovf_q    <= ovf_now;
            if (idx == CW'(1)) dst_q <= in_data;
        end
    end

    // The staged byte count saturates at the buffer depth (R9).
    assert_cnt_bounded_R9: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH));

    // A byte that finds no room always ends in an overflow verdict (R9).
    assert_full_flags_ovf_R9: assert property (@(posedge clk) disable iff (rst)
        (take && in_last && cnt_q == CW'(DEPTH) && !start) |-> end_ev.ovf);

endmodule

// File: rtl/rxf_judge.sv
module rxf_judge
    import rxf_pkg::*;
#(
    parameter int CW = 7,
    parameter int LW = 8,
    localparam int MW = ((CW > LW) ? CW : LW) + 1
) (
    input  pkt_end_t      end_ev,
    input  logic [CW-1:0] end_size,
    input  logic [1:0]    cfg_amode,
    input  byte_t         cfg_own_addr,
    input  logic [1:0]    cfg_lmode,
    input  logic [LW-1:0] cfg_pkt_len,
    output verdict_t      verdict
);

    logic [MW-1:0] size_w, len_w;
    logic          len_ok, addr_ok, mode_ok;
    lmode_e        lm;

    always_comb begin
        lm      = lmode_e'(cfg_lmode);
        size_w  = MW'(end_size);
        len_w   = MW'(cfg_pkt_len);
        mode_ok = lmode_known(lm);
        unique case (lm)
            LMODE_EXACT: len_ok = (size_w == len_w);
            LMODE_UPTO:  len_ok = (size_w <= len_w);
            default:     len_ok = 1'b0;
        endcase
        addr_ok = dest_match(amode_e'(cfg_amode), cfg_own_addr, end_ev.dst, end_ev.have_dst);

        verdict.accept  = end_ev.done && !end_ev.ovf && mode_ok && addr_ok && len_ok;
        verdict.len_err = end_ev.done && !mode_ok;
        verdict.ovf_err = end_ev.done && end_ev.ovf;
    end

    // Verdict outcomes are exclusive of the error pulses (R8, R9).
    always_comb begin
        assert_accept_excl_R8: assert (!(verdict.accept && (verdict.len_err || verdict.ovf_err)));
    end

endmodule

// File: rtl/rxf_store.sv
module rxf_store
    import rxf_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 2)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  byte_t         wr_data,
    input  logic          commit,
    input  logic [CW-1:0] commit_size,
    input  logic          rd_en,
    output byte_t         rd_data,
    output logic [CW-1:0] count,
    output logic [CW-1:0] level
);

    // Two banks: one readable, one staging. Commit swaps their roles.
    byte_t         mem [2][DEPTH];
    logic          act_q;
    logic [CW-1:0] count_q;
    logic [CW-1:0] rd_idx_q;

    always_ff @(posedge clk) begin
        if (wr_en) mem[!act_q][wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q    <= 1'b0;
            count_q  <= '0;
            rd_idx_q <= '0;
        end else if (commit) begin
            act_q    <= !act_q;
            count_q  <= commit_size;
            rd_idx_q <= '0;
        end else if (rd_en && (rd_idx_q < count_q)) begin
            rd_idx_q <= rd_idx_q + CW'(1);
        end
    end

    always_comb begin
        rd_data = (rd_idx_q < count_q) ? mem[act_q][rd_idx_q[AW-1:0]] : 8'h00;
        count   = count_q;
        level   = count_q - rd_idx_q;
    end

    assert_idx_in_range_R12: assert property (@(posedge clk) disable iff (rst)
        rd_idx_q <= count_q);

    assert_count_holds_R11: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(count_q));

    assert_empty_read_R12: assert property (@(posedge clk) disable iff (rst)
        (rd_en && level == '0 && !commit) |=> (level == '0));

    assert_commit_fits_R10: assert property (@(posedge clk) disable iff (rst)
        commit |-> (commit_size != '0 && commit_size <= CW'(DEPTH)));

endmodule

// File: rtl/rx_pkt_filter.sv
module rx_pkt_filter
    import rxf_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int LW = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 2)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          in_first,
    input  logic          in_last,
    input  logic [7:0]    in_data,
    input  logic [1:0]    cfg_amode,
    input  logic [7:0]    cfg_own_addr,
    input  logic [1:0]    cfg_lmode,
    input  logic [LW-1:0] cfg_pkt_len,
    input  logic          rd_en,
    output logic [7:0]    rd_data,
    output logic [CW-1:0] rx_count,
    output logic [CW-1:0] rx_level,
    output logic          rx_irq,
    output logic          len_mode_err,
    output logic          overflow_err
);

    logic          wr_en;
    logic [AW-1:0] wr_addr;
    byte_t         wr_data;
    pkt_end_t      end_ev;
    logic [CW-1:0] end_size;
    verdict_t      verdict;
    verdict_t      verdict_q;

    rxf_collect #(.DEPTH(DEPTH)) u_collect (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_first (in_first),
        .in_last  (in_last),
        .in_data  (in_data),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .end_ev   (end_ev),
        .end_size (end_size)
    );

    rxf_judge #(.CW(CW), .LW(LW)) u_judge (
        .end_ev       (end_ev),
        .end_size     (end_size),
        .cfg_amode    (cfg_amode),
        .cfg_own_addr (cfg_own_addr),
        .cfg_lmode    (cfg_lmode),
        .cfg_pkt_len  (cfg_pkt_len),
        .verdict      (verdict)
    );

    rxf_store #(.DEPTH(DEPTH)) u_store (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .commit      (verdict.accept),
        .commit_size (end_size),
        .rd_en       (rd_en),
        .rd_data     (rd_data),
        .count       (rx_count),
        .level       (rx_level)
    );

    always_ff @(posedge clk) begin
        if (rst) verdict_q <= '0;
        else     verdict_q <= verdict;
    end

    always_comb begin
        rx_irq       = verdict_q.accept;
        len_mode_err = verdict_q.len_err;
        overflow_err = verdict_q.ovf_err;
    end

    // On the pulse, the fresh packet is whole and unread (R10).
    assert_irq_fresh_R10: assert property (@(posedge clk) disable iff (rst)
        rx_irq |-> (rx_level == rx_count && rx_count != '0));

    assert_irq_not_lenerr_R8: assert property (@(posedge clk) disable iff (rst)
        len_mode_err |-> !rx_irq);

    assert_irq_not_ovf_R9: assert property (@(posedge clk) disable iff (rst)
        overflow_err |-> !rx_irq);

    // Without a pulse, the readable count never moves (R11).
    assert_count_only_on_irq_R11: assert property (@(posedge clk) disable iff (rst)
        !rx_irq |-> $stable(rx_count));

endmodule

// File: tb/rx_pkt_filter_test.sv
module rx_pkt_filter_test;

    localparam int DEPTH = 64;
    localparam int LW    = 8;
    localparam int CW    = $clog2(DEPTH + 2);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
    logic [7:0]    in_data = '0;
    logic [1:0]    cfg_amode = '0, cfg_lmode = '0;
    logic [7:0]    cfg_own_addr = '0;
    logic [LW-1:0] cfg_pkt_len = '0;
    logic          rd_en = 1'b0;
    logic [7:0]    rd_data;
    logic [CW-1:0] rx_count, rx_level;
    logic          rx_irq, len_mode_err, overflow_err;

    always #4 clk = ~clk;

    rx_pkt_filter #(.DEPTH(DEPTH), .LW(LW)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first),
        .in_last(in_last), .in_data(in_data), .cfg_amode(cfg_amode),
        .cfg_own_addr(cfg_own_addr), .cfg_lmode(cfg_lmode),
        .cfg_pkt_len(cfg_pkt_len), .rd_en(rd_en), .rd_data(rd_data),
        .rx_count(rx_count), .rx_level(rx_level), .rx_irq(rx_irq),
        .len_mode_err(len_mode_err), .overflow_err(overflow_err)
    );

    int checks = 0;
    int errors = 0;
    int model_mem [DEPTH];
    int m_count = 0;
    int m_idx = 0;

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int pbyte(int k, int dst, int seed);
        if (k == 1) return dst;
        return (seed * 7 + k * 13 + 1) % 256;
    endfunction

    function automatic bit exp_addr(int am, int own, int dst, int len);
        if (am == 0) return 1'b1;
        if (len < 2) return 1'b0;
        if (dst == own) return 1'b1;
        if (am == 2 && dst == 0) return 1'b1;
        if (am == 3 && (dst == 0 || dst == 255)) return 1'b1;
        return 1'b0;
    endfunction

    function automatic bit exp_len(int lm, int plen, int len);
        if (lm == 0) return len == plen;
        if (lm == 1) return len <= plen;
        return 1'b0;
    endfunction

    function automatic string tag_for(int am, int lm, int plen, int own, int dst, int len);
        if (len > DEPTH) return "R9";
        if (lm >= 2) return "R8";
        if (!exp_len(lm, plen, len)) return (lm == 0) ? "R7" : "R6";
        if (am == 0) return "R1";
        if (len < 2) return "R5";
        if (dst == own) return "R2";
        if (am == 2) return "R3";
        if (am == 3) return "R4";
        return "R2";
    endfunction

    // Sends one packet and checks the decision outputs in the cycle after the last byte.
    task automatic send_pkt(input int len, input int dst, input int seed);
        int am, lm, plen, own;
        bit acc;
        string tg;
        am = int'(cfg_amode); lm = int'(cfg_lmode);
        plen = int'(cfg_pkt_len); own = int'(cfg_own_addr);
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_first = (k == 0);
            in_last  = (k == len - 1);
            in_data  = 8'(pbyte(k, dst, seed));
        end
        @(negedge clk);
        in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
        acc = (len <= DEPTH) && exp_addr(am, own, dst, len) && exp_len(lm, plen, len);
        tg  = tag_for(am, lm, plen, own, dst, len);
        check(tg, "rx_irq", int'(rx_irq), int'(acc));
        check("R8", "len_mode_err", int'(len_mode_err), int'(lm >= 2));
        check("R9", "overflow_err", int'(overflow_err), int'(len > DEPTH));
        if (acc) begin
            for (int k = 0; k < len; k++) model_mem[k] = pbyte(k, dst, seed);
            m_count = len;
            m_idx   = 0;
        end
        check(acc ? "R10" : "R11", "rx_count", int'(rx_count), m_count);
        check(acc ? "R10" : "R11", "rx_level", int'(rx_level), m_count - m_idx);
    endtask

    task automatic read_one(input string tag);
        int exp;
        exp = (m_idx < m_count) ? model_mem[m_idx] : 0;
        check(tag, "rd_data", int'(rd_data), exp);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        if (m_idx < m_count) m_idx++;
        check("R12", "rx_level after read", int'(rx_level), m_count - m_idx);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        int dsts [4];
        seed = 1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10", "reset rx_count", int'(rx_count), 0);
        check("R12", "reset rx_level", int'(rx_level), 0);
        check("R12", "reset rd_data", int'(rd_data), 0);
        check("R10", "reset rx_irq", int'(rx_irq), 0);
        check("R8", "reset len_mode_err", int'(len_mode_err), 0);

        cfg_own_addr = 8'h3C;
        cfg_pkt_len  = LW'(5);
        dsts[0] = 8'h3C; dsts[1] = 8'h00; dsts[2] = 8'hFF; dsts[3] = 8'h5A;

        // Full sweep: address modes x length modes x destinations x sizes around the limit.
        for (int am = 0; am < 4; am++) begin
            for (int lm = 0; lm < 4; lm++) begin
                for (int di = 0; di < 4; di++) begin
                    for (int dl = -1; dl <= 1; dl++) begin
                        cfg_amode = 2'(am);
                        cfg_lmode = 2'(lm);
                        send_pkt(5 + dl, dsts[di], seed);
                        seed++;
                        read_one("R10");
                    end
                end
            end
        end

        // Single-byte packets: no destination byte (R5 / R1).
        cfg_lmode = 2'b01;
        for (int am = 0; am < 4; am++) begin
            cfg_amode = 2'(am);
            send_pkt(1, 0, seed);
            seed++;
            read_one("R5");
        end

        // Depth boundary (R9).
        cfg_amode   = 2'b00;
        cfg_lmode   = 2'b01;
        cfg_pkt_len = LW'(255);
        send_pkt(DEPTH, 8'h11, seed); seed++;
        read_one("R10");
        send_pkt(DEPTH + 1, 8'h22, seed); seed++;
        read_one("R11");

        // Drain past empty (R12).
        while (m_idx < m_count) read_one("R10");
        read_one("R12");
        read_one("R12");
        check("R12", "rd_data empty", int'(rd_data), 0);

        // Stray byte outside a packet is ignored (R13).
        send_pkt(3, 8'h44, seed); seed++;
        @(negedge clk);
        in_valid = 1'b1; in_first = 1'b0; in_last = 1'b1; in_data = 8'h99;
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        check("R13", "stray rx_irq", int'(rx_irq), 0);
        check("R13", "stray rx_count", int'(rx_count), 3);
        check("R13", "stray rx_level", int'(rx_level), 3);

        // Restart in mid-packet: three bytes then a new first byte (R13).
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            in_valid = 1'b1; in_first = (k == 0); in_last = 1'b0; in_data = 8'(8'hA0 + k);
        end
        send_pkt(2, 8'h77, seed);
        check("R13", "restart rx_count", int'(rx_count), 2);
        read_one("R13");
        read_one("R13");
        read_one("R12");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule